// File: doc/BRIEF.md
# Linked-Channel Event Transfer Controller

This block moves data on behalf of peripherals without running any processor code. Each channel has a request input. When a request is served, the block copies one byte or one word from a source address to a destination address, using the pointers and control bits stored for that channel. It does this through a memory-move port with a valid/ready handshake. A per-channel count sets how many moves a channel may make. When a normal channel uses up its count, the block raises that channel's interrupt.

Channels are grouped in pairs: an even channel and the odd channel above it. A channel marked as linked passes a request over to its partner once its own count is zero. The block then raises a per-pair link flag, so that software can reload the exhausted channel while the partner carries on. Channels 0 and 2 also have a packet mode. In this mode a second count tracks how many requests have been served, and the interrupt waits until that count runs out.

The move port follows valid/ready rules. Once `mv_valid` rises, `mv_src`, `mv_dst` and `mv_word` stay constant until the cycle in which `mv_ready` is high. That cycle transfers the datum, and `mv_valid` drops the next cycle. Requests that arrive while a move is stalled are queued and are not lost.

Top module: `etc_link_xfer`

## Requirements
- R1: Each channel c has four registers at word address 4c plus an offset. Offset 0 is control: count in bits 7:0, word width in bit 8 (1 = word, 0 = byte), source increment in bit 9, destination increment in bit 10, link in bit 11, packet mode in bit 12. Offset 1 is the source pointer, offset 2 is the destination pointer, and offset 3 is the packet count. Every register resets to zero.
- R2: The link register sits at address 4·NCH. For pair p, the enable bit is at bit 4p and the request bit at bit 4p+1. All other bits read zero, and the register resets to 0x0000.
- R3: A request to a channel in normal mode with a nonzero count produces exactly one move. The move carries that channel's source pointer, destination pointer and width bit. The count then drops by one.
- R4: After each move, a pointer whose increment bit is set advances by 1 for a byte move or by 2 for a word move. It wraps modulo 2^PW. A pointer whose increment bit is clear does not change.
- R5: When a move brings the count of an unlinked normal channel to zero, that channel's interrupt pulses high for one cycle, in the cycle after the accepting edge. A linked channel reaching zero raises no interrupt.
- R6: Suppose a request reaches a linked channel whose count is zero, and the partner's count is nonzero. The move then uses the partner's pointers and width, and the partner's count is decremented. The pair's link request bit is set, and the requesting channel's registers stay unchanged.
- R7: Suppose a request reaches a channel in normal mode whose count is zero, and either its link bit is clear or its partner's count is also zero. No move happens. The requesting channel's interrupt pulses for one cycle, and no link request bit is set.
- R8: The link interrupt of a pair is high exactly while both its enable bit and its request bit are set. Software clears the request bit by writing 0 to it.
- R9: Packet mode applies only to the channels selected by PKT_MASK (channels 0 and 2 by default). On other channels, the packet bit and the packet count read as zero and have no effect. In packet mode each request moves one datum, decrements the packet count and leaves the count unchanged. The interrupt pulses when the packet count reaches zero. A request that arrives when the packet count is already zero raises the interrupt and makes no move.
- R10: Requests that arrive while a move waits for ready are held pending. They are then served lowest channel number first. Several requests on a channel that is already pending merge into a single service.
- R11: While `mv_valid` is high and `mv_ready` is low, the move fields stay stable. After each accepted move, `mv_valid` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| svc_req | input | NCH | Per-channel service request, one bit per channel |
| mv_valid | output | 1 | Move request valid |
| mv_ready | input | 1 | Move accepted in this cycle |
| mv_src | output | PW | Source address of the move |
| mv_dst | output | PW | Destination address of the move |
| mv_word | output | 1 | 1 = word move, 0 = byte move |
| chan_irq | output | NCH | One-cycle channel interrupt pulses |
| link_irq | output | NCH/2 | Per-pair link interrupt level |

## Verification
The bench builds the block with NCH=4 and PW=8. That gives two pairs, with packet mode on channel 0 and on channel 2. With 8-bit pointers, the modulo wrap of both byte and word increments shows up within a few moves. The bench sweeps all eight combinations of width and increment bits, starting from pointers just below the wrap point. It also tests the linked handover together with the case where the partner is exhausted. The small channel count lets one stalled move hold requests on every other channel, which exercises the lowest-first ordering and the merging of repeated requests.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int CNT_W = 8;
  localparam int REG_W = 16;

  typedef struct packed {
    logic             pkt;
    logic             link;
    logic             dinc;
    logic             sinc;
    logic             word;
    logic [CNT_W-1:0] cnt;
  } chan_ctrl_t;

  typedef enum logic [1:0] {ACT_NONE, ACT_MOVE, ACT_IRQ} act_e;
  typedef enum logic {ST_IDLE, ST_MOVE} eng_st_e;

  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_SRC  = 2'd1;
  localparam logic [1:0] OFF_DST  = 2'd2;
  localparam logic [1:0] OFF_CNT2 = 2'd3;
endpackage

// File: rtl/etc_arbiter.sv
module etc_arbiter #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest pending channel wins
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/etc_regfile.sv
module etc_regfile
  import etc_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          PW       = 16,
  parameter logic [7:0]  PKT_MASK = 8'h05,
  localparam int         RA       = $clog2(NCH * 4 + 1),
  localparam int         NP       = NCH / 2,
  localparam int         CW       = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_we,
  input  logic [RA-1:0]        sw_addr,
  input  logic [REG_W-1:0]     sw_wdata,
  input  logic                 hw_we,
  input  logic [CW-1:0]        hw_ch,
  input  logic [CNT_W-1:0]     hw_cnt,
  input  logic [PW-1:0]        hw_src,
  input  logic [PW-1:0]        hw_dst,
  input  logic [CNT_W-1:0]     hw_cnt2,
  input  logic [NP-1:0]        hw_link_set,
  output chan_ctrl_t           ctrl [NCH],
  output logic [PW-1:0]        src  [NCH],
  output logic [PW-1:0]        dst  [NCH],
  output logic [CNT_W-1:0]     cnt2 [NCH],
  output logic [NP-1:0]        link_en,
  output logic [NP-1:0]        link_req,
  output logic [REG_W-1:0]     rdata
);
  localparam logic [RA-1:0] LINK_ADDR = RA'(NCH * 4);

  logic unused_wdata;
  assign unused_wdata = ^sw_wdata[REG_W-1:13];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [RA-1:0] BASE = RA'(c * 4);
    logic       sel_ctrl, sel_src, sel_dst, hw_hit;
    chan_ctrl_t ctrl_q;
    logic [PW-1:0] src_q, dst_q;

    assign sel_ctrl = sw_we && (sw_addr == (BASE | RA'(OFF_CTRL)));
    assign sel_src  = sw_we && (sw_addr == (BASE | RA'(OFF_SRC)));
    assign sel_dst  = sw_we && (sw_addr == (BASE | RA'(OFF_DST)));
    assign hw_hit   = hw_we && (hw_ch == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        src_q  <= '0;
        dst_q  <= '0;
      end else begin
        if (sel_ctrl)
          ctrl_q <= {PKT_MASK[c] & sw_wdata[12], sw_wdata[11:8], sw_wdata[CNT_W-1:0]};
        else if (hw_hit)
          ctrl_q.cnt <= hw_cnt;
        if (sel_src)     src_q <= sw_wdata[PW-1:0];
        else if (hw_hit) src_q <= hw_src;
        if (sel_dst)     dst_q <= sw_wdata[PW-1:0];
        else if (hw_hit) dst_q <= hw_dst;
      end
    end

    assign ctrl[c] = ctrl_q;
    assign src[c]  = src_q;
    assign dst[c]  = dst_q;

    if (PKT_MASK[c]) begin : g_cnt2
      logic [CNT_W-1:0] cnt2_q;
      logic sel_cnt2;
      assign sel_cnt2 = sw_we && (sw_addr == (BASE | RA'(OFF_CNT2)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt2_q <= '0;
        else if (sel_cnt2) cnt2_q <= sw_wdata[CNT_W-1:0];
        else if (hw_hit)   cnt2_q <= hw_cnt2;
      end
      assign cnt2[c] = cnt2_q;
    end else begin : g_no_cnt2
      assign cnt2[c] = '0;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic en_q, req_q, sel_link;
    assign sel_link = sw_we && (sw_addr == LINK_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        req_q <= 1'b0;
      end else if (sel_link) begin
        en_q  <= sw_wdata[4*p];
        req_q <= sw_wdata[4*p+1] | hw_link_set[p];
      end else begin
        req_q <= req_q | hw_link_set[p];
      end
    end
    assign link_en[p]  = en_q;
    assign link_req[p] = req_q;
  end

  logic [CW-1:0] rd_ch;
  assign rd_ch = CW'(sw_addr >> 2);

  always_comb begin
    rdata = '0;
    if (sw_addr < LINK_ADDR) begin
      case (sw_addr[1:0])
        OFF_CTRL: rdata = REG_W'(ctrl[rd_ch]);
        OFF_SRC:  rdata = REG_W'(src[rd_ch]);
        OFF_DST:  rdata = REG_W'(dst[rd_ch]);
        default:  rdata = REG_W'(cnt2[rd_ch]);
      endcase
    end else if (sw_addr == LINK_ADDR) begin
      for (int p = 0; p < NP; p++) begin
        rdata[4*p]   = link_en[p];
        rdata[4*p+1] = link_req[p];
      end
    end
  end
endmodule

// File: rtl/etc_engine.sv
module etc_engine
  import etc_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          PW       = 16,
  parameter logic [7:0]  PKT_MASK = 8'h05,
  localparam int         NP       = NCH / 2,
  localparam int         CW       = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 any,
  input  logic [CW-1:0]        sel,
  input  chan_ctrl_t           ctrl [NCH],
  input  logic [PW-1:0]        src  [NCH],
  input  logic [PW-1:0]        dst  [NCH],
  input  logic [CNT_W-1:0]     cnt2 [NCH],
  input  logic                 mv_ready,
  output logic [NCH-1:0]       clr,
  output logic                 mv_valid,
  output logic [PW-1:0]        mv_src,
  output logic [PW-1:0]        mv_dst,
  output logic                 mv_word,
  output logic                 hw_we,
  output logic [CW-1:0]        hw_ch,
  output logic [CNT_W-1:0]     hw_cnt,
  output logic [PW-1:0]        hw_src,
  output logic [PW-1:0]        hw_dst,
  output logic [CNT_W-1:0]     hw_cnt2,
  output logic [NP-1:0]        hw_link_set,
  output logic [NCH-1:0]       irq
);
  eng_st_e         state_q;
  logic [CW-1:0]   tgt_q;
  logic            pkt_q, hand_q, word_q;
  logic [PW-1:0]   src_q, dst_q;
  logic [NCH-1:0]  irq_q;

  act_e            act;
  logic [CW-1:0]   tgt, partner;
  logic            pkt_sel, hand;

  assign partner = sel ^ CW'(1);

  // decide what the lowest pending request turns into
  always_comb begin
    act     = ACT_NONE;
    tgt     = sel;
    pkt_sel = 1'b0;
    hand    = 1'b0;
    if (state_q == ST_IDLE && any) begin
      if (PKT_MASK[sel] && ctrl[sel].pkt) begin
        pkt_sel = 1'b1;
        act     = (cnt2[sel] != '0) ? ACT_MOVE : ACT_IRQ;
      end else if (ctrl[sel].cnt != '0) begin
        act = ACT_MOVE;
      end else if (ctrl[sel].link && ctrl[partner].cnt != '0) begin
        act  = ACT_MOVE;
        tgt  = partner;
        hand = 1'b1;
      end else begin
        act = ACT_IRQ;
      end
    end
  end

  always_comb begin
    clr = '0;
    if (act != ACT_NONE) clr[sel] = 1'b1;
  end

  logic          done;
  logic [PW-1:0] step;
  chan_ctrl_t    tc;

  assign done = (state_q == ST_MOVE) && mv_ready;
  assign step = word_q ? PW'(2) : PW'(1);
  assign tc   = ctrl[tgt_q];

  assign hw_we   = done;
  assign hw_ch   = tgt_q;
  assign hw_cnt  = pkt_q ? tc.cnt : tc.cnt - CNT_W'(1);
  assign hw_cnt2 = pkt_q ? cnt2[tgt_q] - CNT_W'(1) : cnt2[tgt_q];
  assign hw_src  = tc.sinc ? src[tgt_q] + step : src[tgt_q];
  assign hw_dst  = tc.dinc ? dst[tgt_q] + step : dst[tgt_q];

  always_comb begin
    hw_link_set = '0;
    if (done && hand_q) hw_link_set[tgt_q >> 1] = 1'b1;
  end

  logic fire;
  assign fire = pkt_q ? (cnt2[tgt_q] == CNT_W'(1))
                      : (tc.cnt == CNT_W'(1) && !tc.link);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      pkt_q   <= 1'b0;
      hand_q  <= 1'b0;
      word_q  <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      irq_q   <= '0;
    end else begin
      irq_q <= '0;
      if (act == ACT_IRQ) irq_q[sel] <= 1'b1;
      if (done && fire)   irq_q[tgt_q] <= 1'b1;
      if (act == ACT_MOVE) begin
        state_q <= ST_MOVE;
        tgt_q   <= tgt;
        pkt_q   <= pkt_sel;
        hand_q  <= hand;
        word_q  <= ctrl[tgt].word;
        src_q   <= src[tgt];
        dst_q   <= dst[tgt];
      end else if (done) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign mv_valid = (state_q == ST_MOVE);
  assign mv_src   = src_q;
  assign mv_dst   = dst_q;
  assign mv_word  = word_q;
  assign irq      = irq_q;
endmodule

// File: rtl/etc_link_xfer.sv
module etc_link_xfer
  import etc_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          PW       = 16,
  parameter logic [7:0]  PKT_MASK = 8'h05,
  localparam int         RA       = $clog2(NCH * 4 + 1),
  localparam int         NP       = NCH / 2,
  localparam int         CW       = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RA-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NCH-1:0]   svc_req,
  output logic             mv_valid,
  input  logic             mv_ready,
  output logic [PW-1:0]    mv_src,
  output logic [PW-1:0]    mv_dst,
  output logic             mv_word,
  output logic [NCH-1:0]   chan_irq,
  output logic [NP-1:0]    link_irq
);
  chan_ctrl_t       ctrl [NCH];
  logic [PW-1:0]    src  [NCH];
  logic [PW-1:0]    dst  [NCH];
  logic [CNT_W-1:0] cnt2 [NCH];
  logic [NP-1:0]    link_en, link_req, hw_link_set;
  logic             hw_we, any;
  logic [CW-1:0]    hw_ch, sel;
  logic [CNT_W-1:0] hw_cnt, hw_cnt2;
  logic [PW-1:0]    hw_src, hw_dst;
  logic [NCH-1:0]   pend_q, clr;

  // pending requests: a new request outranks the clear of the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | svc_req;
  end

  etc_arbiter #(.N(NCH)) u_arb (
    .pend (pend_q),
    .any  (any),
    .idx  (sel)
  );

  etc_regfile #(.NCH(NCH), .PW(PW), .PKT_MASK(PKT_MASK)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (reg_we),
    .sw_addr     (reg_addr),
    .sw_wdata    (reg_wdata),
    .hw_we       (hw_we),
    .hw_ch       (hw_ch),
    .hw_cnt      (hw_cnt),
    .hw_src      (hw_src),
    .hw_dst      (hw_dst),
    .hw_cnt2     (hw_cnt2),
    .hw_link_set (hw_link_set),
    .ctrl        (ctrl),
    .src         (src),
    .dst         (dst),
    .cnt2        (cnt2),
    .link_en     (link_en),
    .link_req    (link_req),
    .rdata       (reg_rdata)
  );

  etc_engine #(.NCH(NCH), .PW(PW), .PKT_MASK(PKT_MASK)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .any         (any),
    .sel         (sel),
    .ctrl        (ctrl),
    .src         (src),
    .dst         (dst),
    .cnt2        (cnt2),
    .mv_ready    (mv_ready),
    .clr         (clr),
    .mv_valid    (mv_valid),
    .mv_src      (mv_src),
    .mv_dst      (mv_dst),
    .mv_word     (mv_word),
    .hw_we       (hw_we),
    .hw_ch       (hw_ch),
    .hw_cnt      (hw_cnt),
    .hw_src      (hw_src),
    .hw_dst      (hw_dst),
    .hw_cnt2     (hw_cnt2),
    .hw_link_set (hw_link_set),
    .irq         (chan_irq)
  );

  assign link_irq = link_en & link_req;
endmodule

// File: rtl/etc_link_xfer_chk.sv
module etc_link_xfer_chk #(
  parameter int NCH = 8,
  parameter int PW  = 16,
  localparam int RA = $clog2(NCH * 4 + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RA-1:0]  reg_addr,
  input logic [15:0]    reg_rdata,
  input logic           mv_valid,
  input logic           mv_ready,
  input logic [PW-1:0]  mv_src,
  input logic [PW-1:0]  mv_dst,
  input logic           mv_word,
  input logic [NCH-1:0] chan_irq
);
  function automatic logic [15:0] link_mask();
    logic [15:0] m = '0;
    for (int p = 0; p < NCH / 2; p++) begin
      m[4*p]   = 1'b1;
      m[4*p+1] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [15:0]   LMASK     = link_mask();
  localparam logic [RA-1:0] LINK_ADDR = RA'(NCH * 4);

  AST_MOVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_src) && $stable(mv_dst) && $stable(mv_word)); // R11
  AST_ONE_DATUM: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && mv_ready |=> !mv_valid); // R11
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_irq)); // R5
  AST_IRQ_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq != '0) |-> !mv_valid); // R7
  AST_LINK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == LINK_ADDR) |-> ((reg_rdata & ~LMASK) == 16'h0)); // R2
endmodule

bind etc_link_xfer etc_link_xfer_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .mv_valid  (mv_valid),
  .mv_ready  (mv_ready),
  .mv_src    (mv_src),
  .mv_dst    (mv_dst),
  .mv_word   (mv_word),
  .chan_irq  (chan_irq)
);

// File: tb/tb_etc_link_xfer.sv
module tb_etc_link_xfer;
  localparam int NCH = 4;
  localparam int PW  = 8;
  localparam int RA  = 5;
  localparam logic [RA-1:0] LA = 5'd16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, reg_we = 1'b0, mv_ready = 1'b0;
  logic [RA-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] svc_req = '0, chan_irq;
  logic mv_valid, mv_word;
  logic [PW-1:0] mv_src, mv_dst;
  logic [1:0] link_irq;

  etc_link_xfer #(.NCH(NCH), .PW(PW), .PKT_MASK(8'h05)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_req(svc_req),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_src(mv_src), .mv_dst(mv_dst),
    .mv_word(mv_word), .chan_irq(chan_irq), .link_irq(link_irq)
  );

  int n_tests = 0, n_fail = 0;
  logic [15:0] rv;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [RA-1:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [RA-1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(int ch);
    svc_req[ch] = 1'b1;
    @(negedge clk);
    svc_req = '0;
  endtask

  task automatic wait_valid(string tag);
    for (int n = 0; n < 20 && !mv_valid; n++) @(negedge clk);
    chk({tag, " valid"}, mv_valid, 1'b1);
  endtask

  task automatic move(logic [PW-1:0] s, logic [PW-1:0] d, logic w,
                      logic [NCH-1:0] irq_exp, string tag);
    wait_valid(tag);
    chk({tag, " src"}, mv_src, s);
    chk({tag, " dst"}, mv_dst, d);
    chk({tag, " word"}, mv_word, w);
    mv_ready = 1'b1;
    @(negedge clk);
    mv_ready = 1'b0;
    chk({tag, " irq"}, chan_irq, irq_exp);
  endtask

  task automatic no_move(logic [NCH-1:0] irq_exp, string tag);
    @(negedge clk);
    chk({tag, " irq"}, chan_irq, irq_exp);
    chk({tag, " no move"}, mv_valid, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset state
    rd(5'd0, rv);  chk("R1 ctrl reset", rv, 16'h0);
    rd(5'd1, rv);  chk("R1 src reset", rv, 16'h0);
    rd(LA, rv);    chk("R2 link reset", rv, 16'h0);
    chk("R1 idle", {mv_valid, chan_irq, link_irq}, 0);

    // R2 link register layout
    wr(LA, 16'hFFFF);
    rd(LA, rv);    chk("R2 link bits", rv, 16'h0033);
    chk("R8 both pairs", link_irq, 2'b11);
    wr(LA, 16'h0000);
    chk("R8 cleared", link_irq, 2'b00);

    // R3 R4 R5 sweep over width and increment bits on channel 1
    for (int k = 0; k < 8; k++) begin
      logic w, si, di;
      logic [PW-1:0] s0, d0, st;
      w = k[0]; si = k[1]; di = k[2];
      s0 = 8'hFE; d0 = 8'hFD;
      st = w ? 8'd2 : 8'd1;
      wr(5'd4, 16'((int'(di) << 10) | (int'(si) << 9) | (int'(w) << 8) | 2));
      wr(5'd5, 16'(s0));
      wr(5'd6, 16'(d0));
      pulse(1);
      move(s0, d0, w, 4'b0000, "R3 first");
      rd(5'd4, rv); chk("R3 count dec", rv[7:0], 8'd1);
      pulse(1);
      move(s0 + (si ? st : 8'd0), d0 + (di ? st : 8'd0), w, 4'b0010, "R4 second/R5 irq");
      rd(5'd5, rv); chk("R4 src wrap", rv, 16'(8'(s0 + (si ? 2 * st : 8'd0))));
      rd(5'd6, rv); chk("R4 dst wrap", rv, 16'(8'(d0 + (di ? 2 * st : 8'd0))));
      @(negedge clk);
      chk("R5 pulse one cycle", chan_irq, 4'b0000);
    end

    // R7 count zero, unlinked
    pulse(1);
    no_move(4'b0010, "R7 unlinked zero");

    // R6 handover 2 -> 3
    wr(5'd8, 16'h0800); wr(5'd9, 16'h40); wr(5'd10, 16'h50);
    wr(5'd12, 16'h0701); wr(5'd13, 16'h80); wr(5'd14, 16'h90);
    pulse(2);
    move(8'h80, 8'h90, 1'b1, 4'b1000, "R6 handover");
    rd(LA, rv);   chk("R6 link req set", rv, 16'h0020);
    chk("R8 not enabled", link_irq, 2'b00);
    rd(5'd13, rv); chk("R6 partner src", rv, 16'h82);
    rd(5'd12, rv); chk("R6 partner count", rv, 16'h0700);
    rd(5'd8, rv);  chk("R6 own ctrl kept", rv, 16'h0800);
    wr(LA, 16'h0030);
    chk("R8 enabled", link_irq, 2'b10);
    wr(LA, 16'h0010);
    chk("R8 sw clear", link_irq, 2'b00);

    // R7 partner exhausted too
    pulse(2);
    no_move(4'b0100, "R7 partner empty");
    rd(LA, rv);   chk("R7 no link set", rv, 16'h0010);

    // R5 linked channel reaching zero: no interrupt
    wr(5'd8, 16'h0801);
    pulse(2);
    move(8'h40, 8'h50, 1'b0, 4'b0000, "R5 linked no irq");
    rd(5'd8, rv); chk("R5 linked count", rv, 16'h0800);

    // R9 packet mode on channel 0
    wr(5'd0, 16'h1205); wr(5'd3, 16'h3); wr(5'd1, 16'h20); wr(5'd2, 16'h30);
    for (int i = 0; i < 3; i++) begin
      pulse(0);
      move(8'(8'h20 + i), 8'h30, 1'b0, (i == 2) ? 4'b0001 : 4'b0000, "R9 packet");
    end
    rd(5'd3, rv); chk("R9 cnt2 zero", rv, 16'h0);
    rd(5'd0, rv); chk("R9 count kept", rv, 16'h1205);
    pulse(0);
    no_move(4'b0001, "R9 cnt2 empty");

    // R9 packet bit ignored on channel 1
    wr(5'd4, 16'h1003); wr(5'd7, 16'h5); wr(5'd5, 16'h60); wr(5'd6, 16'h70);
    rd(5'd4, rv); chk("R9 pkt bit ignored", rv, 16'h0003);
    rd(5'd7, rv); chk("R9 cnt2 absent", rv, 16'h0);
    pulse(1);
    move(8'h60, 8'h70, 1'b0, 4'b0000, "R9 normal path");
    rd(5'd4, rv); chk("R9 count dec", rv, 16'h0002);

    // R10 R11 pending order under back-pressure
    wr(5'd8, 16'h0003);
    wr(5'd12, 16'h0003); wr(5'd13, 16'h80); wr(5'd14, 16'h90);
    pulse(2);
    wait_valid("R10 first");
    pulse(3); pulse(1); pulse(3);
    chk("R11 held src", mv_src, 8'h40);
    chk("R11 held valid", mv_valid, 1'b1);
    mv_ready = 1'b1;
    @(negedge clk);
    mv_ready = 1'b0;
    move(8'h60, 8'h70, 1'b0, 4'b0000, "R10 lowest first");
    move(8'h80, 8'h90, 1'b0, 4'b0000, "R10 then ch3");
    repeat (4) @(negedge clk);
    chk("R10 merged", mv_valid, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule